// File: doc/BRIEF.md
# Dual-Port Mailbox with Hardware Semaphore

This block is a small register mailbox shared by two masters on one clock. One is an internal processor-side port and the other is an external host port. Each port has a plain request/write strobe, a 9-bit byte address, 8-bit write data and combinational read data. Through the mailbox the two sides pass command bytes to each other and share a data buffer. A protected 2-bit semaphore lets either side claim the buffer before it uses it.

Each command register serves one direction. A write into it raises the interrupt toward the other side when that interrupt is enabled, and the other side reading the register clears the interrupt. With the enables off, software polls the command registers instead. The semaphore is taken or returned by writing a code and reading the register back. If the value read back is not the value written, the operation failed and software retries. Hardware never blocks buffer accesses made without the semaphore.

The address map is: 0x000 outbound command (internal to external), 0x001 inbound command (external to internal), 0x002 semaphore, 0x003 control, 0x004 interrupt enable, and 0x100–0x1FF data buffer.

Top module: `dual_mailbox`

## Requirements
- R1: After reset every register and buffer byte reads 0x00, the semaphore is free (00), and `irq_int` and `irq_ext` are low.
- R2: Both command registers (0x000, 0x001) can be written and read back from either port. If both ports write the same command register in one cycle, the internal value is kept.
- R3: Control (0x003) and interrupt enable (0x004) are written and read only by the internal port. From the external port, writes to them have no effect and reads return 0x00.
- R4: The semaphore reads as 0x00 free, 0x01 held by internal, or 0x02 held by external. A claim is a write of the requester's own code (internal 0x01, external 0x02) and succeeds only when the semaphore is free. The readback equals the written value exactly when the claim succeeded.
- R5: A write of 0x00 to the semaphore releases it only when the writer is the current holder. Otherwise the value is unchanged.
- R6: Any other write to the semaphore leaves it unchanged. This covers 0x03, any value with upper bits set, and the other side's claim code.
- R7: If both ports claim a free semaphore in the same cycle, the internal port gets it (0x01).
- R8: A write by the internal port to 0x000 sets an external pending flag. `irq_ext` equals that flag AND control bit 0. The flag clears when the external port reads 0x000, and it is kept while masked.
- R9: A write by the external port to 0x001 sets an internal pending flag. `irq_int` equals that flag AND enable bit 0. An internal read of 0x001 clears the flag. If a set and a clear fall in the same cycle, the set wins.
- R10: Buffer bytes at 0x100–0x1FF are shared by both ports without any semaphore check. The byte index is the address modulo BUF_DEPTH (default 32, so 0x105 and 0x125 alias). If both ports write one byte in the same cycle, the internal value is kept.
- R11: Addresses 0x005–0x0FF read 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_req | input | 1 | Internal port access strobe |
| int_we | input | 1 | Internal port write (1) or read (0) |
| int_addr | input | 9 | Internal port byte address |
| int_wdata | input | 8 | Internal port write data |
| int_rdata | output | 8 | Internal port read data, combinational from address |
| ext_req | input | 1 | External port access strobe |
| ext_we | input | 1 | External port write (1) or read (0) |
| ext_addr | input | 9 | External port byte address |
| ext_wdata | input | 8 | External port write data |
| ext_rdata | output | 8 | External port read data, combinational from address |
| irq_int | output | 1 | Interrupt toward the internal processor |
| irq_ext | output | 1 | Interrupt toward the external host |

## Verification
Two kinds of event can land in the same clock, and the bench provokes both by driving the two ports together in one cycle. In the first, both sides claim a free semaphore at once. The judgment is that both sides then read 0x01. In the second, the external port writes the inbound command register while the internal port reads it, so the pending flag is set and cleared together. The internal read must return the old byte, and `irq_int` must be high in the next cycle. Same-cycle writes to one command register and to one buffer byte are also checked, and the internal value must survive.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int MB_AW = 9;
  localparam int MB_DW = 8;

  localparam logic [7:0] OFS_CMD_OUT = 8'h00;
  localparam logic [7:0] OFS_CMD_IN  = 8'h01;
  localparam logic [7:0] OFS_SEM     = 8'h02;
  localparam logic [7:0] OFS_CTRL    = 8'h03;
  localparam logic [7:0] OFS_IEN     = 8'h04;

  typedef enum logic [1:0] {
    SEM_FREE = 2'b00,
    SEM_INT  = 2'b01,
    SEM_EXT  = 2'b10
  } sem_t;

  typedef struct packed {
    logic cmd_out;
    logic cmd_in;
    logic sem;
    logic ctrl;
    logic ien;
    logic buf_;
  } hit_t;

  // Byte a side must write to claim the semaphore.
  function automatic logic [MB_DW-1:0] sem_claim_code(input logic is_int);
    return is_int ? {6'b0, SEM_INT} : {6'b0, SEM_EXT};
  endfunction

  // Next semaphore state; internal side is evaluated first.
  function automatic sem_t sem_step(input sem_t cur, input logic i_claim, input logic i_rel,
                                    input logic e_claim, input logic e_rel);
    case (cur)
      SEM_FREE: begin
        if (i_claim)      return SEM_INT;
        else if (e_claim) return SEM_EXT;
        else              return SEM_FREE;
      end
      SEM_INT: return i_rel ? SEM_FREE : SEM_INT;
      SEM_EXT: return e_rel ? SEM_FREE : SEM_EXT;
      default: return SEM_FREE;
    endcase
  endfunction

  // Read-data selection shared by both ports.
  function automatic logic [MB_DW-1:0] rd_mux(input hit_t h, input logic [MB_DW-1:0] cmd_out,
                                             input logic [MB_DW-1:0] cmd_in, input sem_t sem,
                                             input logic [MB_DW-1:0] ctrl, input logic [MB_DW-1:0] ien,
                                             input logic [MB_DW-1:0] bufd);
    logic [MB_DW-1:0] r;
    r = '0;
    if (h.cmd_out) r = cmd_out;
    if (h.cmd_in)  r = cmd_in;
    if (h.sem)     r = {6'b0, sem};
    if (h.ctrl)    r = ctrl;
    if (h.ien)     r = ien;
    if (h.buf_)    r = bufd;
    return r;
  endfunction

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter bit PRIV   = 1'b1,
  parameter int BUF_AW = 5
) (
  input  logic [MB_AW-1:0]  addr,
  output hit_t              hit,
  output logic [BUF_AW-1:0] buf_idx
);
  always_comb begin
    hit = '0;
    if (addr[MB_AW-1]) begin
      hit.buf_ = 1'b1;
    end else begin
      case (addr[MB_AW-2:0])
        OFS_CMD_OUT: hit.cmd_out = 1'b1;
        OFS_CMD_IN:  hit.cmd_in  = 1'b1;
        OFS_SEM:     hit.sem     = 1'b1;
        OFS_CTRL:    hit.ctrl    = PRIV;
        OFS_IEN:     hit.ien     = PRIV;
        default:     hit         = '0;
      endcase
    end
  end

  assign buf_idx = addr[BUF_AW-1:0];
endmodule

// File: rtl/mbox_sema.sv
module mbox_sema
  import mbox_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_wr,
  input  logic [MB_DW-1:0] int_wdata,
  input  logic             ext_wr,
  input  logic [MB_DW-1:0] ext_wdata,
  output sem_t             state
);
  logic i_claim, i_rel, e_claim, e_rel;

  assign i_claim = int_wr && (int_wdata == sem_claim_code(1'b1));
  assign i_rel   = int_wr && (int_wdata == '0);
  assign e_claim = ext_wr && (ext_wdata == sem_claim_code(1'b0));
  assign e_rel   = ext_wr && (ext_wdata == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEM_FREE;
    else        state <= sem_step(state, i_claim, i_rel, e_claim, e_rel);
  end
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  input  logic enable,
  output logic irq
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (set_ev) pend_q <= 1'b1;
    else if (clr_ev) pend_q <= 1'b0;
  end

  assign irq = pend_q & enable;
endmodule

// File: rtl/mbox_buffer.sv
module mbox_buffer
  import mbox_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_we,
  input  logic [AW-1:0]    a_idx,
  input  logic [MB_DW-1:0] a_wd,
  input  logic             b_we,
  input  logic [AW-1:0]    b_idx,
  input  logic [MB_DW-1:0] b_wd,
  output logic [MB_DW-1:0] a_rd,
  output logic [MB_DW-1:0] b_rd
);
  logic [MB_DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       mem[g] <= '0;
      else if (a_we && a_idx == AW'(g)) mem[g] <= a_wd;
      else if (b_we && b_idx == AW'(g)) mem[g] <= b_wd;
    end
  end

  assign a_rd = mem[a_idx];
  assign b_rd = mem[b_idx];
endmodule

// File: rtl/dual_mailbox.sv
module dual_mailbox
  import mbox_pkg::*;
#(
  parameter int BUF_DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       int_req,
  input  logic       int_we,
  input  logic [8:0] int_addr,
  input  logic [7:0] int_wdata,
  output logic [7:0] int_rdata,
  input  logic       ext_req,
  input  logic       ext_we,
  input  logic [8:0] ext_addr,
  input  logic [7:0] ext_wdata,
  output logic [7:0] ext_rdata,
  output logic       irq_int,
  output logic       irq_ext
);
  localparam int BUF_AW = $clog2(BUF_DEPTH);

  hit_t              ih, eh;
  logic [BUF_AW-1:0] iidx, eidx;
  logic [MB_DW-1:0]  ibuf, ebuf;
  logic [MB_DW-1:0]  cmd_out_q, cmd_in_q, ctrl_q, ien_q;
  sem_t              sem_state;

  logic i_wr, i_rd, e_wr, e_rd;
  assign i_wr = int_req &  int_we;
  assign i_rd = int_req & ~int_we;
  assign e_wr = ext_req &  ext_we;
  assign e_rd = ext_req & ~ext_we;

  // Named events for the checker and interrupt logic
  logic ev_out_post, ev_out_take, ev_in_post, ev_in_take;
  assign ev_out_post = i_wr & ih.cmd_out;
  assign ev_out_take = e_rd & eh.cmd_out;
  assign ev_in_post  = e_wr & eh.cmd_in;
  assign ev_in_take  = i_rd & ih.cmd_in;

  mbox_decode #(.PRIV(1'b1), .BUF_AW(BUF_AW)) u_dec_int (
    .addr(int_addr), .hit(ih), .buf_idx(iidx));
  mbox_decode #(.PRIV(1'b0), .BUF_AW(BUF_AW)) u_dec_ext (
    .addr(ext_addr), .hit(eh), .buf_idx(eidx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_out_q <= '0;
      cmd_in_q  <= '0;
      ctrl_q    <= '0;
      ien_q     <= '0;
    end else begin
      if (i_wr & ih.cmd_out)      cmd_out_q <= int_wdata;
      else if (e_wr & eh.cmd_out) cmd_out_q <= ext_wdata;
      if (i_wr & ih.cmd_in)       cmd_in_q  <= int_wdata;
      else if (e_wr & eh.cmd_in)  cmd_in_q  <= ext_wdata;
      if (i_wr & ih.ctrl)         ctrl_q    <= int_wdata;
      if (i_wr & ih.ien)          ien_q     <= int_wdata;
    end
  end

  mbox_sema u_sema (
    .clk(clk), .rst_n(rst_n),
    .int_wr(i_wr & ih.sem), .int_wdata(int_wdata),
    .ext_wr(e_wr & eh.sem), .ext_wdata(ext_wdata),
    .state(sem_state));

  mbox_irq u_irq_ext (
    .clk(clk), .rst_n(rst_n), .set_ev(ev_out_post), .clr_ev(ev_out_take),
    .enable(ctrl_q[0]), .irq(irq_ext));
  mbox_irq u_irq_int (
    .clk(clk), .rst_n(rst_n), .set_ev(ev_in_post), .clr_ev(ev_in_take),
    .enable(ien_q[0]), .irq(irq_int));

  mbox_buffer #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .a_we(i_wr & ih.buf_), .a_idx(iidx), .a_wd(int_wdata),
    .b_we(e_wr & eh.buf_), .b_idx(eidx), .b_wd(ext_wdata),
    .a_rd(ibuf), .b_rd(ebuf));

  assign int_rdata = rd_mux(ih, cmd_out_q, cmd_in_q, sem_state, ctrl_q, ien_q, ibuf);
  assign ext_rdata = rd_mux(eh, cmd_out_q, cmd_in_q, sem_state, ctrl_q, ien_q, ebuf);
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       int_req,
  input logic       int_we,
  input logic [8:0] int_addr,
  input logic [7:0] int_wdata,
  input logic       ext_req,
  input logic       ext_we,
  input logic [8:0] ext_addr,
  input logic [7:0] ext_wdata,
  input logic [1:0] sem_q,
  input logic [7:0] ctrl_q,
  input logic [7:0] ien_q,
  input logic       irq_int,
  input logic       irq_ext
);
  logic i_sem_wr, e_sem_wr, i_claim, i_rel, e_claim, e_rel, i_cfg_wr, e_post;
  assign i_sem_wr = int_req && int_we && int_addr == 9'h002;
  assign e_sem_wr = ext_req && ext_we && ext_addr == 9'h002;
  assign i_claim  = i_sem_wr && int_wdata == 8'h01;
  assign i_rel    = i_sem_wr && int_wdata == 8'h00;
  assign e_claim  = e_sem_wr && ext_wdata == 8'h02;
  assign e_rel    = e_sem_wr && ext_wdata == 8'h00;
  assign i_cfg_wr = int_req && int_we && (int_addr == 9'h003 || int_addr == 9'h004);
  assign e_post   = ext_req && ext_we && ext_addr == 9'h001;

  p_sem_code_r4: assert property (@(posedge clk) disable iff (!rst_n) sem_q != 2'b11);

  p_int_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_q == 2'b01 && !i_rel) |=> sem_q == 2'b01);

  p_ext_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_q == 2'b10 && !e_rel) |=> sem_q == 2'b10);

  p_free_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_q == 2'b00 && !i_claim && !e_claim) |=> sem_q == 2'b00);

  p_tie_int_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_q == 2'b00 && i_claim) |=> sem_q == 2'b01);

  p_cfg_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !i_cfg_wr |=> ($stable(ctrl_q) && $stable(ien_q)));

  p_ext_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |-> !irq_ext);

  p_int_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (e_post && ien_q[0]) |=> irq_int);
endmodule

bind dual_mailbox mbox_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .int_req(int_req), .int_we(int_we), .int_addr(int_addr), .int_wdata(int_wdata),
  .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
  .sem_q(sem_state), .ctrl_q(ctrl_q), .ien_q(ien_q),
  .irq_int(irq_int), .irq_ext(irq_ext));

// File: tb/dual_mailbox_test.sv
module dual_mailbox_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       int_req = 1'b0, int_we = 1'b0;
  logic [8:0] int_addr = '0;
  logic [7:0] int_wdata = '0;
  logic       ext_req = 1'b0, ext_we = 1'b0;
  logic [8:0] ext_addr = '0;
  logic [7:0] ext_wdata = '0;
  logic [7:0] int_rdata, ext_rdata;
  logic       irq_int, irq_ext;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Scoreboard: kind 0 int_rdata, 1 ext_rdata, 2 irq_int, 3 irq_ext
  int         kq[$];
  logic [7:0] eq[$];
  string      tq[$];

  always #10 clk = ~clk;

  dual_mailbox uut (
    .clk(clk), .rst_n(rst_n),
    .int_req(int_req), .int_we(int_we), .int_addr(int_addr), .int_wdata(int_wdata),
    .int_rdata(int_rdata),
    .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_rdata(ext_rdata), .irq_int(irq_int), .irq_ext(irq_ext));

  localparam logic [8:0] A_OUT = 9'h000, A_IN = 9'h001, A_SEM = 9'h002,
                         A_CTRL = 9'h003, A_IEN = 9'h004;

  task automatic op(input bit ie, input bit iw, input logic [8:0] ia, input logic [7:0] id,
                    input bit ee, input bit ew, input logic [8:0] ea, input logic [7:0] ed);
    @(negedge clk);
    int_req = ie; int_we = iw; int_addr = ia; int_wdata = id;
    ext_req = ee; ext_we = ew; ext_addr = ea; ext_wdata = ed;
  endtask

  task automatic push(input int k, input logic [7:0] e, input string t);
    kq.push_back(k); eq.push_back(e); tq.push_back(t);
  endtask

  task automatic idle();                          op(0,0,0,0, 0,0,0,0); endtask
  task automatic wr_i(input logic [8:0] a, input logic [7:0] d); op(1,1,a,d, 0,0,0,0); endtask
  task automatic wr_e(input logic [8:0] a, input logic [7:0] d); op(0,0,0,0, 1,1,a,d); endtask
  task automatic rd_i(input logic [8:0] a, input logic [7:0] e, input string t);
    op(1,0,a,0, 0,0,0,0); push(0, e, t);
  endtask
  task automatic rd_e(input logic [8:0] a, input logic [7:0] e, input string t);
    op(0,0,0,0, 1,0,a,0); push(1, e, t);
  endtask
  task automatic chk_irq(input int k, input bit e, input string t);
    idle(); push(k, {7'b0, e}, t);
  endtask

  // Monitor: compares mid-way between the falling and next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (kq.size() > 0) begin
        int k;
        logic [7:0] exp, act;
        string t;
        k = kq.pop_front(); exp = eq.pop_front(); t = tq.pop_front();
        case (k)
          0: act = int_rdata;
          1: act = ext_rdata;
          2: act = {7'b0, irq_int};
          default: act = {7'b0, irq_ext};
        endcase
        checks++;
        if (act !== exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_i(A_SEM, 8'h00, "R1 sem");
    rd_i(A_OUT, 8'h00, "R1 cmd_out");
    rd_e(A_IN, 8'h00, "R1 cmd_in");
    rd_i(9'h100, 8'h00, "R1 buffer");
    chk_irq(2, 0, "R1 irq_int");
    chk_irq(3, 0, "R1 irq_ext");
    // R3 privileged configuration
    wr_i(A_CTRL, 8'h01);
    wr_e(A_CTRL, 8'hFE);
    rd_i(A_CTRL, 8'h01, "R3 ctrl kept");
    rd_e(A_CTRL, 8'h00, "R3 ext ctrl read");
    wr_i(A_IEN, 8'h01);
    wr_e(A_IEN, 8'h00);
    rd_i(A_IEN, 8'h01, "R3 ien kept");
    rd_e(A_IEN, 8'h00, "R3 ext ien read");
    // R8 outbound interrupt
    wr_i(A_OUT, 8'h5A);
    chk_irq(3, 1, "R8 irq_ext raised");
    chk_irq(2, 0, "R8 irq_int quiet");
    rd_e(A_OUT, 8'h5A, "R8 ext reads cmd");
    chk_irq(3, 0, "R8 irq_ext cleared");
    // R9 inbound interrupt
    wr_e(A_IN, 8'h33);
    chk_irq(2, 1, "R9 irq_int raised");
    rd_i(A_IN, 8'h33, "R9 int reads cmd");
    chk_irq(2, 0, "R9 irq_int cleared");
    // R9 set and clear in one cycle: set wins, read sees old byte
    op(1,0,A_IN,0, 1,1,A_IN,8'h44); push(0, 8'h33, "R9 same-cycle old data");
    chk_irq(2, 1, "R9 set wins");
    rd_i(A_IN, 8'h44, "R9 new data");
    chk_irq(2, 0, "R9 cleared after");
    // R8 masking keeps pending
    wr_i(A_CTRL, 8'h00);
    wr_i(A_OUT, 8'h11);
    chk_irq(3, 0, "R8 masked");
    wr_i(A_CTRL, 8'h01);
    chk_irq(3, 1, "R8 pending kept");
    rd_e(A_OUT, 8'h11, "R8 read masked cmd");
    chk_irq(3, 0, "R8 cleared");
    // R2 command registers from both sides
    wr_e(A_OUT, 8'h77);
    rd_i(A_OUT, 8'h77, "R2 ext write out reg");
    wr_i(A_IN, 8'h9C);
    rd_e(A_IN, 8'h9C, "R2 int write in reg");
    op(1,1,A_IN,8'hA1, 1,1,A_IN,8'hB2);
    rd_e(A_IN, 8'hA1, "R2 same-cycle internal wins");
    rd_i(A_IN, 8'hA1, "R2 internal reread");
    chk_irq(2, 0, "R2 irq_int cleared");
    // R4 R5 R6 semaphore
    wr_i(A_SEM, 8'h02);
    rd_i(A_SEM, 8'h00, "R6 int writes ext code");
    wr_i(A_SEM, 8'h03);
    rd_i(A_SEM, 8'h00, "R6 value 3");
    wr_i(A_SEM, 8'h01);
    rd_i(A_SEM, 8'h01, "R4 int claim ok");
    wr_e(A_SEM, 8'h02);
    rd_e(A_SEM, 8'h01, "R4 ext claim fails");
    wr_e(A_SEM, 8'h00);
    rd_e(A_SEM, 8'h01, "R5 non-holder release");
    wr_i(A_SEM, 8'h00);
    rd_e(A_SEM, 8'h00, "R5 holder release");
    wr_e(A_SEM, 8'h82);
    rd_e(A_SEM, 8'h00, "R6 upper bits set");
    wr_e(A_SEM, 8'h02);
    rd_e(A_SEM, 8'h02, "R4 ext claim ok");
    wr_e(A_SEM, 8'h01);
    rd_i(A_SEM, 8'h02, "R6 ext writes int code");
    wr_i(A_SEM, 8'h00);
    rd_i(A_SEM, 8'h02, "R5 int cannot release ext");
    wr_i(A_SEM, 8'h01);
    rd_i(A_SEM, 8'h02, "R4 int claim fails");
    wr_e(A_SEM, 8'h00);
    rd_i(A_SEM, 8'h00, "R5 ext releases");
    // R7 simultaneous claim
    op(1,1,A_SEM,8'h01, 1,1,A_SEM,8'h02);
    op(1,0,A_SEM,0, 1,0,A_SEM,0);
    push(0, 8'h01, "R7 int readback");
    push(1, 8'h01, "R7 ext readback");
    wr_i(A_SEM, 8'h00);
    // R10 buffer without semaphore
    wr_e(9'h105, 8'hC3);
    rd_i(9'h105, 8'hC3, "R10 shared byte");
    rd_i(9'h125, 8'hC3, "R10 alias");
    wr_i(9'h11F, 8'h44);
    rd_e(9'h13F, 8'h44, "R10 alias top");
    op(1,1,9'h10A,8'h01, 1,1,9'h10A,8'h02);
    rd_e(9'h10A, 8'h01, "R10 same-cycle internal wins");
    // R11 unmapped
    wr_i(9'h050, 8'hFF);
    rd_i(9'h050, 8'h00, "R11 unmapped int");
    wr_e(9'h0FF, 8'hFF);
    rd_e(9'h0FF, 8'h00, "R11 unmapped ext");
    rd_i(A_OUT, 8'h77, "R11 no side effect");
    idle();
    idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule